// File: doc/BRIEF.md
# Serial flash operation sequencer

This block runs one complete serial-flash operation each time it gets a start pulse: a read into a byte stream, a page program from a byte stream, or an erase. It builds the command, address, dummy and data phases itself. It also picks the opcode and the lane width of each phase from an encoded read mode, write mode or erase size. The serial side has a clock, an active-low select, and four IO lanes. Each lane is split into an output value, an output enable and an input value, so the pad ring can form the bidirectional pins.

Configuration inputs are sampled when a task is accepted and must stay stable while the task runs. They set the following:
- the read and write mode;
- 24- or 32-bit addressing;
- the SCK divisor;
- the clock mode;
- a select timing count.

Write bytes arrive on a valid/ready pair. Read bytes leave as single-cycle valid strobes. A ready pulse closes every task, including one that is rejected.

Top module: `sflash_seq`

## Requirements
- R1: After reset, `cs_n` is 1, `busy` is 0, `io_oe` is 0, `ready` is 0, and `sck` rests at the level chosen by `sck_mode3`.
- R2: The `rd_mode` encoding sets the opcode, the address lanes, the data lanes and the dummy SCK cycles, as follows:
  - 0 gives 0x0B, lanes 1/1, 8 dummy cycles.
  - 1 gives 0x3B, lanes 1/2, 8 dummy cycles.
  - 2 gives 0xBB, lanes 2/2, 4 dummy cycles.
  - 3 gives 0x6B, lanes 1/4, 8 dummy cycles.
  - 4 gives 0xEB, lanes 4/4, 8 dummy cycles.
  - The opcode is always sent on one lane.
- R3: The `wr_mode` encoding sets the opcode and the address/data lanes, with no dummy cycles: 0 gives 0x02 (1/1), 1 gives 0xA2 (1/2), 2 gives 0x32 (1/4), 3 gives 0x38 (4/4).
- R4: The `erase_sel` encoding selects the erase command. 0 gives 0x20 followed by an address. 1 gives 0xD8 followed by an address. 2 or 3 gives 0xC7 with no address and nothing after the opcode.
- R5: The address follows the opcode, MSB first. It has 24 bits (`xfer_addr[23:0]`) when `addr_32` is 0 and 32 bits when `addr_32` is 1.
- R6: `io_oe` is zero while `cs_n` is high. It is also zero for the whole data phase of a read. During the dummy cycles the address lanes stay driven, so the lanes turn to input exactly at the first data cycle.
- R7: Lane packing works as follows:
  - A one-lane phase drives `io_out[0]` and reads `io_in[1]`.
  - A two-lane phase uses `{io[1],io[0]}`.
  - A four-lane phase uses `io[3:0]`.
  - In every case the higher lane carries the more significant bit, and each byte goes MSB first.
- R8: The SCK period is 2*(`sck_div`+1) cycles of `clk`.
- R9: With `sck_mode3`=0 SCK idles low; with `sck_mode3`=1 it idles high. In both modes read data is sampled in the high half of SCK, after the rising edge.
- R10: Select timing is set by `cs_gap`. The first SCK rising edge comes `cs_gap`+1+`sck_div`+1 cycles after `cs_n` falls. `cs_n` then stays high for `cs_gap`+1 cycles after the last SCK edge before `ready` pulses.
- R11: A block erase (`erase_sel` 0 or 1) whose `xfer_addr[1:0]` is not zero is rejected. `err_align` is set, `ready` pulses, and the serial pins see no activity.
- R12: Every task ends with exactly one single-cycle `ready` pulse. `busy` is high from acceptance until that pulse and low during it.
- R13: A start pulse that arrives while `busy` is high is ignored and sets `overrun`. Both `overrun` and `err_align` clear when the next task is accepted.
- R14: While a write byte is wanted (`wdata_ready`=1) and `wdata_valid` is 0, SCK holds still. Each byte is taken on a cycle where both are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| go_read | input | 1 | Start a read task (highest priority) |
| go_prog | input | 1 | Start a program task |
| go_erase | input | 1 | Start an erase task |
| rd_mode | input | 3 | Read mode encoding |
| wr_mode | input | 2 | Write mode encoding |
| erase_sel | input | 2 | Erase size encoding |
| addr_32 | input | 1 | 1 selects 32-bit addressing |
| sck_div | input | DIV_W | SCK divisor minus one |
| sck_mode3 | input | 1 | 1 selects idle-high clock mode |
| cs_gap | input | GAP_W | Select setup and high time count |
| xfer_addr | input | 32 | Flash start address |
| xfer_len | input | LEN_W | Data length in bytes |
| wdata | input | 8 | Write byte |
| wdata_valid | input | 1 | Write byte available |
| wdata_ready | output | 1 | Write byte wanted |
| rdata | output | 8 | Read byte |
| rdata_valid | output | 1 | Read byte strobe |
| sck | output | 1 | Serial clock |
| cs_n | output | 1 | Active-low select |
| io_out | output | 4 | Lane output values |
| io_oe | output | 4 | Lane output enables |
| io_in | input | 4 | Lane input values |
| busy | output | 1 | Task in progress |
| ready | output | 1 | Task completion pulse |
| err_align | output | 1 | Misaligned erase rejected |
| overrun | output | 1 | Start ignored while busy |

## Verification
The hardest case to reach is the turn of the lanes at the boundary between the dummy and data phases. It has to be seen together with data arriving in time from a device. The bench therefore models the flash side. It counts SCK rising edges inside each select window and places each read bit on the lanes after the preceding falling edge, using the edge index and the expected dummy offset. As a result, a turn one cycle early or late shows up as a wrong byte or a wrong enable. The write stall is reached by holding `wdata_valid` low after `wdata_ready` rises and checking that SCK and the edge count stay frozen.

// File: rtl/sfs_pkg.sv
package sfs_pkg;

  typedef enum logic [1:0] {ST_IDLE, ST_SETUP, ST_SHIFT, ST_GAP} state_e;
  typedef enum logic [1:0] {PS_CMD, PS_ADDR, PS_DUM, PS_DATA} phase_e;

  // lane width encoded as log2: 0 -> 1 lane, 1 -> 2 lanes, 2 -> 4 lanes
  typedef struct packed {
    logic [7:0] op;
    logic [1:0] alg;
    logic [1:0] dlg;
    logic [3:0] dummy;
    logic       has_addr;
    logic       has_data;
  } plan_t;

  function automatic plan_t read_plan(input logic [2:0] m);
    case (m)
      3'd1:    return '{op: 8'h3B, alg: 2'd0, dlg: 2'd1, dummy: 4'd8, has_addr: 1'b1, has_data: 1'b1};
      3'd2:    return '{op: 8'hBB, alg: 2'd1, dlg: 2'd1, dummy: 4'd4, has_addr: 1'b1, has_data: 1'b1};
      3'd3:    return '{op: 8'h6B, alg: 2'd0, dlg: 2'd2, dummy: 4'd8, has_addr: 1'b1, has_data: 1'b1};
      3'd4:    return '{op: 8'hEB, alg: 2'd2, dlg: 2'd2, dummy: 4'd8, has_addr: 1'b1, has_data: 1'b1};
      default: return '{op: 8'h0B, alg: 2'd0, dlg: 2'd0, dummy: 4'd8, has_addr: 1'b1, has_data: 1'b1};
    endcase
  endfunction

  function automatic plan_t write_plan(input logic [1:0] m);
    case (m)
      2'd1:    return '{op: 8'hA2, alg: 2'd0, dlg: 2'd1, dummy: 4'd0, has_addr: 1'b1, has_data: 1'b1};
      2'd2:    return '{op: 8'h32, alg: 2'd0, dlg: 2'd2, dummy: 4'd0, has_addr: 1'b1, has_data: 1'b1};
      2'd3:    return '{op: 8'h38, alg: 2'd2, dlg: 2'd2, dummy: 4'd0, has_addr: 1'b1, has_data: 1'b1};
      default: return '{op: 8'h02, alg: 2'd0, dlg: 2'd0, dummy: 4'd0, has_addr: 1'b1, has_data: 1'b1};
    endcase
  endfunction

  function automatic plan_t erase_plan(input logic [1:0] s);
    case (s)
      2'd0:    return '{op: 8'h20, alg: 2'd0, dlg: 2'd0, dummy: 4'd0, has_addr: 1'b1, has_data: 1'b0};
      2'd1:    return '{op: 8'hD8, alg: 2'd0, dlg: 2'd0, dummy: 4'd0, has_addr: 1'b1, has_data: 1'b0};
      default: return '{op: 8'hC7, alg: 2'd0, dlg: 2'd0, dummy: 4'd0, has_addr: 1'b0, has_data: 1'b0};
    endcase
  endfunction

endpackage

// File: rtl/sfs_rstsync.sv
module sfs_rstsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_s = chain_q[STAGES-1];
endmodule

// File: rtl/sfs_halfclk.sv
module sfs_halfclk #(
  parameter int DIV_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [DIV_W-1:0] div,
  output logic             ph,
  output logic             half_end
);
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             ph_q, ph_d;

  always_comb begin
    cnt_d = cnt_q;
    ph_d  = ph_q;
    if (!en) begin
      cnt_d = '0;
    end else if (cnt_q == div) begin
      cnt_d = '0;
      ph_d  = ~ph_q;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ph_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      ph_q  <= ph_d;
    end
  end

  assign ph       = ph_q;
  assign half_end = en && (cnt_q == div);

  // R8: a disabled divider never moves the phase
  p_phase_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(ph_q));
endmodule

// File: rtl/sfs_lanes.sv
module sfs_lanes (
  input  logic [1:0] lg,
  input  logic       drive,
  input  logic [3:0] sr_top,
  input  logic [3:0] io_in,
  input  logic [7:0] rx_in,
  output logic [3:0] io_out,
  output logic [3:0] io_oe,
  output logic [7:0] rx_next
);
  always_comb begin
    case (lg)
      2'd1: begin
        io_out  = {2'b00, sr_top[3:2]};
        io_oe   = 4'b0011;
        rx_next = {rx_in[5:0], io_in[1:0]};
      end
      2'd2: begin
        io_out  = sr_top;
        io_oe   = 4'b1111;
        rx_next = {rx_in[3:0], io_in};
      end
      default: begin
        io_out  = {3'b000, sr_top[3]};
        io_oe   = 4'b0001;
        rx_next = {rx_in[6:0], io_in[1]};
      end
    endcase
    if (!drive) begin
      io_out = 4'b0000;
      io_oe  = 4'b0000;
    end
  end
endmodule

// File: rtl/sflash_seq.sv
module sflash_seq #(
  parameter int LEN_W = 16,
  parameter int DIV_W = 4,
  parameter int GAP_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go_read,
  input  logic             go_prog,
  input  logic             go_erase,
  input  logic [2:0]       rd_mode,
  input  logic [1:0]       wr_mode,
  input  logic [1:0]       erase_sel,
  input  logic             addr_32,
  input  logic [DIV_W-1:0] sck_div,
  input  logic             sck_mode3,
  input  logic [GAP_W-1:0] cs_gap,
  input  logic [31:0]      xfer_addr,
  input  logic [LEN_W-1:0] xfer_len,
  input  logic [7:0]       wdata,
  input  logic             wdata_valid,
  output logic             wdata_ready,
  output logic [7:0]       rdata,
  output logic             rdata_valid,
  output logic             sck,
  output logic             cs_n,
  output logic [3:0]       io_out,
  output logic [3:0]       io_oe,
  input  logic [3:0]       io_in,
  output logic             busy,
  output logic             ready,
  output logic             err_align,
  output logic             overrun
);
  import sfs_pkg::*;

  localparam int SR_W = 40;
  localparam int CW   = 6;

  logic            rst_s;
  state_e          st_q, st_d;
  phase_e          phs_q, phs_d;
  plan_t           plan_q, plan_d, pl;
  logic            rd_q, rd_d, wr_q, wr_d, a32_q, a32_d, need_q, need_d;
  logic [LEN_W-1:0] len_q, len_d;
  logic [CW-1:0]   cnt_q, cnt_d;
  logic [SR_W-1:0] sr_q, sr_d;
  logic [7:0]      rx_q, rx_d, rdat_q, rdat_d, rx_next;
  logic [GAP_W-1:0] gcnt_q, gcnt_d;
  logic            rdy_q, rdy_d, rv_q, rv_d, err_q, err_d, ovr_q, ovr_d;
  logic            ph, half_end, cyc_end, div_en, drive, go_any, finish, enter_data;
  logic [1:0]      cur_lg;

  sfs_rstsync u_rs (.clk(clk), .rst_n(rst_n), .rst_s(rst_s));

  assign div_en  = (st_q == ST_SHIFT) && !need_q;
  assign cyc_end = half_end && ph;

  sfs_halfclk #(.DIV_W(DIV_W)) u_hc (
    .clk(clk), .rst_n(rst_s), .en(div_en), .div(sck_div), .ph(ph), .half_end(half_end));

  assign cur_lg = (phs_q == PS_CMD)  ? 2'd0 :
                  (phs_q == PS_DATA) ? plan_q.dlg : plan_q.alg;
  assign drive  = (st_q == ST_SHIFT) && !((phs_q == PS_DATA) && rd_q);

  sfs_lanes u_ln (
    .lg(cur_lg), .drive(drive), .sr_top(sr_q[SR_W-1 -: 4]), .io_in(io_in),
    .rx_in(rx_q), .io_out(io_out), .io_oe(io_oe), .rx_next(rx_next));

  assign go_any = go_read | go_prog | go_erase;

  always_comb begin
    st_d = st_q;  phs_d = phs_q;  plan_d = plan_q;  rd_d = rd_q;  wr_d = wr_q;
    a32_d = a32_q;  need_d = need_q;  len_d = len_q;  cnt_d = cnt_q;  sr_d = sr_q;
    rx_d = rx_q;  rdat_d = rdat_q;  gcnt_d = gcnt_q;  err_d = err_q;  ovr_d = ovr_q;
    rdy_d = 1'b0;  rv_d = 1'b0;  finish = 1'b0;  enter_data = 1'b0;
    pl = go_read ? read_plan(rd_mode) : go_prog ? write_plan(wr_mode) : erase_plan(erase_sel);
    case (st_q)
      ST_IDLE: if (go_any) begin
        ovr_d = 1'b0;
        err_d = 1'b0;
        if (!go_read && !go_prog && pl.has_addr && (xfer_addr[1:0] != 2'b00)) begin
          err_d = 1'b1;
          rdy_d = 1'b1;
        end else begin
          st_d   = ST_SETUP;   gcnt_d = cs_gap;   plan_d = pl;
          rd_d   = go_read;    wr_d   = !go_read && go_prog;
          a32_d  = addr_32;    len_d  = xfer_len;
          phs_d  = PS_CMD;     cnt_d  = CW'(8);   need_d = 1'b0;
          sr_d   = addr_32 ? {pl.op, xfer_addr} : {pl.op, xfer_addr[23:0], 8'h00};
        end
      end
      ST_SETUP: begin
        if (gcnt_q == '0) st_d = ST_SHIFT;
        else              gcnt_d = gcnt_q - 1'b1;
      end
      ST_SHIFT: begin
        if (need_q) begin
          if (wdata_valid) begin
            sr_d[SR_W-1 -: 8] = wdata;
            need_d = 1'b0;
          end
        end else if (cyc_end) begin
          sr_d = sr_q << (1 << cur_lg);
          if ((phs_q == PS_DATA) && rd_q) rx_d = rx_next;
          if (cnt_q == CW'(1)) begin
            case (phs_q)
              PS_CMD: begin
                if (plan_q.has_addr) begin
                  phs_d = PS_ADDR;
                  cnt_d = (a32_q ? CW'(32) : CW'(24)) >> plan_q.alg;
                end else begin
                  finish = 1'b1;
                end
              end
              PS_ADDR: begin
                if (plan_q.dummy != '0) begin
                  phs_d = PS_DUM;
                  cnt_d = CW'(plan_q.dummy);
                end else if (plan_q.has_data && (len_q != '0)) begin
                  enter_data = 1'b1;
                end else begin
                  finish = 1'b1;
                end
              end
              PS_DUM: begin
                if (plan_q.has_data && (len_q != '0)) enter_data = 1'b1;
                else                                  finish = 1'b1;
              end
              default: begin
                if (rd_q) begin
                  rv_d   = 1'b1;
                  rdat_d = rx_next;
                end
                len_d = len_q - 1'b1;
                if (len_q == LEN_W'(1)) finish = 1'b1;
                else                    enter_data = 1'b1;
              end
            endcase
          end else begin
            cnt_d = cnt_q - 1'b1;
          end
        end
        if (enter_data) begin
          phs_d  = PS_DATA;
          cnt_d  = CW'(8) >> plan_q.dlg;
          need_d = wr_q;
        end
        if (finish) begin
          st_d   = ST_GAP;
          gcnt_d = cs_gap;
        end
      end
      default: begin
        if (gcnt_q == '0) begin
          st_d  = ST_IDLE;
          rdy_d = 1'b1;
        end else begin
          gcnt_d = gcnt_q - 1'b1;
        end
      end
    endcase
    if ((st_q != ST_IDLE) && go_any) ovr_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      st_q <= ST_IDLE;  phs_q <= PS_CMD;  plan_q <= '0;  rd_q <= 1'b0;  wr_q <= 1'b0;
      a32_q <= 1'b0;  need_q <= 1'b0;  len_q <= '0;  cnt_q <= '0;  sr_q <= '0;
      rx_q <= '0;  rdat_q <= '0;  gcnt_q <= '0;  rdy_q <= 1'b0;  rv_q <= 1'b0;
      err_q <= 1'b0;  ovr_q <= 1'b0;
    end else begin
      st_q <= st_d;  phs_q <= phs_d;  plan_q <= plan_d;  rd_q <= rd_d;  wr_q <= wr_d;
      a32_q <= a32_d;  need_q <= need_d;  len_q <= len_d;  cnt_q <= cnt_d;  sr_q <= sr_d;
      rx_q <= rx_d;  rdat_q <= rdat_d;  gcnt_q <= gcnt_d;  rdy_q <= rdy_d;  rv_q <= rv_d;
      err_q <= err_d;  ovr_q <= ovr_d;
    end
  end

  assign sck         = (st_q == ST_SHIFT) ? ph : sck_mode3;
  assign cs_n        = !((st_q == ST_SETUP) || (st_q == ST_SHIFT));
  assign busy        = (st_q != ST_IDLE);
  assign ready       = rdy_q;
  assign rdata       = rdat_q;
  assign rdata_valid = rv_q;
  assign err_align   = err_q;
  assign overrun     = ovr_q;
  assign wdata_ready = need_q;

  p_ready_idle_r12: assert property (@(posedge clk) disable iff (!rst_s)
    ready |-> (!busy && cs_n));
  p_oe_off_r6: assert property (@(posedge clk) disable iff (!rst_s)
    cs_n |-> (io_oe == 4'b0000));
  p_rd_input_r6: assert property (@(posedge clk) disable iff (!rst_s)
    rdata_valid |-> (io_oe == 4'b0000));
  p_sck_idle_r9: assert property (@(posedge clk) disable iff (!rst_s)
    cs_n |-> (sck == sck_mode3));
  p_overrun_r13: assert property (@(posedge clk) disable iff (!rst_s)
    (busy && go_any) |=> overrun);
  p_reject_quiet_r11: assert property (@(posedge clk) disable iff (!rst_s)
    $rose(err_align) |-> (cs_n && ready && !busy));
  p_stall_r14: assert property (@(posedge clk) disable iff (!rst_s)
    (wdata_ready && !wdata_valid) |=> $stable(sck));
endmodule

// File: tb/sim_sflash_seq.sv
module sim_sflash_seq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic go_read = 0, go_prog = 0, go_erase = 0;
  logic [2:0] rd_mode = 0;
  logic [1:0] wr_mode = 0, erase_sel = 0;
  logic addr_32 = 0, sck_mode3 = 0;
  logic [3:0] sck_div = 0, cs_gap = 0;
  logic [31:0] xfer_addr = 0;
  logic [15:0] xfer_len = 0;
  logic [7:0] wdata;
  logic wdata_valid = 1'b1;
  logic wdata_ready, rdata_valid, sck, cs_n, busy, ready, err_align, overrun;
  logic [7:0] rdata;
  logic [3:0] io_out, io_oe;
  logic [3:0] io_in = 4'h0;

  int checks = 0, fails = 0;
  int tcnt = 0, nrise = 0, nready = 0, ncsf = 0, nrd = 0, widx = 0;
  int t_csfall = 0, t_csrise = 0, t_first = 0, t_second = 0, t_ready = 0;
  int exp_D = 0, exp_L = 1;
  bit rd_active = 0, hs_pend = 0, sck_q = 0, cs_q = 1;
  logic [3:0] cap_out [0:511];
  logic [3:0] cap_oe  [0:511];
  logic [7:0] rbuf [0:63];

  always #2.5 clk = ~clk;

  sflash_seq u0 (
    .clk(clk), .rst_n(rst_n), .go_read(go_read), .go_prog(go_prog), .go_erase(go_erase),
    .rd_mode(rd_mode), .wr_mode(wr_mode), .erase_sel(erase_sel), .addr_32(addr_32),
    .sck_div(sck_div), .sck_mode3(sck_mode3), .cs_gap(cs_gap), .xfer_addr(xfer_addr),
    .xfer_len(xfer_len), .wdata(wdata), .wdata_valid(wdata_valid), .wdata_ready(wdata_ready),
    .rdata(rdata), .rdata_valid(rdata_valid), .sck(sck), .cs_n(cs_n), .io_out(io_out),
    .io_oe(io_oe), .io_in(io_in), .busy(busy), .ready(ready), .err_align(err_align),
    .overrun(overrun));

  function automatic logic [7:0] rbyte(int j);
    return 8'h5A ^ 8'(j * 61);
  endfunction
  function automatic logic [7:0] wbyte(int j);
    return 8'hC3 + 8'(j * 23);
  endfunction
  assign wdata = wbyte(widx);

  function automatic logic [3:0] rd_nib(int k);
    int off, sh;
    logic [7:0] v;
    if (!rd_active || k < exp_D) return 4'h0;
    off = (k - exp_D) * exp_L;
    sh  = 8 - exp_L - (off % 8);
    v   = (rbyte(off / 8) >> sh) & 8'((1 << exp_L) - 1);
    if (exp_L == 1) return {2'b00, v[0], 1'b0};
    return v[3:0];
  endfunction

  // flash-side model and monitors, evaluated away from the active edge
  always @(negedge clk) begin
    tcnt++;
    if (hs_pend) widx++;
    hs_pend = wdata_ready && wdata_valid;
    if (cs_q && !cs_n) begin nrise = 0; t_csfall = tcnt; ncsf++; io_in = rd_nib(0); end
    if (!cs_q && cs_n) t_csrise = tcnt;
    if (!cs_n && sck && !sck_q) begin
      cap_out[nrise] = io_out; cap_oe[nrise] = io_oe;
      if (nrise == 0) t_first = tcnt;
      if (nrise == 1) t_second = tcnt;
      nrise++;
    end
    if (!cs_n && !sck && sck_q) io_in = rd_nib(nrise);
    if (rdata_valid) begin rbuf[nrd] = rdata; nrd++; end
    if (ready) begin nready++; t_ready = tcnt; end
    sck_q = sck; cs_q = cs_n;
  end

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] seg(int s, int n, int L);
    logic [31:0] v = 0;
    for (int i = 0; i < n; i++) begin
      if (L == 1)      v = {v[30:0], cap_out[s+i][0]};
      else if (L == 2) v = {v[29:0], cap_out[s+i][1:0]};
      else             v = {v[27:0], cap_out[s+i]};
    end
    return v;
  endfunction

  function automatic bit oe_all(int s, int n, logic [3:0] m);
    for (int i = 0; i < n; i++) if (cap_oe[s+i] !== m) return 0;
    return 1;
  endfunction

  function automatic logic [3:0] mask(int L);
    return (L == 1) ? 4'h1 : (L == 2) ? 4'h3 : 4'hF;
  endfunction

  task automatic pulse(input int which);
    @(negedge clk);
    if (which == 0) go_read = 1; else if (which == 1) go_prog = 1; else go_erase = 1;
    @(negedge clk);
    go_read = 0; go_prog = 0; go_erase = 0;
  endtask

  task automatic wait_ready(input int n0);
    while (nready == n0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic set_cfg(input bit a32, input int div, input bit m3, input int gap,
                         input logic [31:0] addr, input int len);
    addr_32 = a32; sck_div = 4'(div); sck_mode3 = m3; cs_gap = 4'(gap);
    xfer_addr = addr; xfer_len = 16'(len);
  endtask

  task automatic common_checks(input string tag, input int edges, input int div, input int gap,
                               input logic [7:0] op, input int ab, input logic [31:0] addr,
                               input int al, input int n0);
    check(nrise == edges, {tag, " R2/R3 edge count"}, nrise, edges);
    check(seg(0, 8, 1) == {24'h0, op} && oe_all(0, 8, 4'h1), {tag, " R2 opcode"}, seg(0, 8, 1), op);
    if (ab > 0)
      check(seg(8, ab / al, al) == addr && oe_all(8, ab / al, mask(al)), {tag, " R5 address"},
            seg(8, ab / al, al), addr);
    check(t_first - t_csfall == gap + div + 2, {tag, " R10 setup"}, t_first - t_csfall, gap + div + 2);
    check(t_second - t_first == 2 * (div + 1), {tag, " R8 period"}, t_second - t_first, 2 * (div + 1));
    check(t_ready - t_csrise == gap + 1, {tag, " R10 gap"}, t_ready - t_csrise, gap + 1);
    check(nready == n0 + 1 && !busy && cs_n, {tag, " R12 ready once"}, nready, n0 + 1);
    check(sck == sck_mode3 && io_oe == 0, {tag, " R9 idle"}, sck, sck_mode3);
  endtask

  task automatic do_read(input int m, input bit a32, input int div, input bit m3, input int gap,
                         input logic [31:0] addr, input int len);
    logic [7:0] op; int al, dl, dm, ab, n0, bad;
    case (m)
      1: begin op = 8'h3B; al = 1; dl = 2; dm = 8; end
      2: begin op = 8'hBB; al = 2; dl = 2; dm = 4; end
      3: begin op = 8'h6B; al = 1; dl = 4; dm = 8; end
      4: begin op = 8'hEB; al = 4; dl = 4; dm = 8; end
      default: begin op = 8'h0B; al = 1; dl = 1; dm = 8; end
    endcase
    ab = a32 ? 32 : 24;
    set_cfg(a32, div, m3, gap, addr, len); rd_mode = 3'(m);
    exp_D = 8 + ab / al + dm; exp_L = dl; rd_active = 1; nrd = 0; n0 = nready;
    pulse(0); wait_ready(n0); rd_active = 0;
    common_checks($sformatf("read m%0d", m), exp_D + len * 8 / dl, div, gap, op, ab,
                  a32 ? addr : {8'h0, addr[23:0]}, al, n0);
    check(cap_oe[exp_D-1] == mask(al) && oe_all(exp_D, len * 8 / dl, 4'h0),
          "R6 lane turn at data start", cap_oe[exp_D], 0);
    bad = 0;
    for (int j = 0; j < len; j++) if (rbuf[j] !== rbyte(j)) bad++;
    check(nrd == len && bad == 0, $sformatf("R7 read bytes m%0d", m), rbuf[0], rbyte(0));
  endtask

  task automatic do_prog(input int m, input bit a32, input int div, input int gap,
                         input logic [31:0] addr, input int len, input bit stall);
    logic [7:0] op; int al, dl, ab, n0, D, bad, r0; bit s0;
    case (m)
      1: begin op = 8'hA2; al = 1; dl = 2; end
      2: begin op = 8'h32; al = 1; dl = 4; end
      3: begin op = 8'h38; al = 4; dl = 4; end
      default: begin op = 8'h02; al = 1; dl = 1; end
    endcase
    ab = a32 ? 32 : 24; D = 8 + ab / al;
    set_cfg(a32, div, 0, gap, addr, len); wr_mode = 2'(m);
    widx = 0; hs_pend = 0; n0 = nready;
    if (stall) wdata_valid = 0;
    pulse(1);
    if (stall) begin
      while (!wdata_ready) @(negedge clk);
      s0 = sck; r0 = nrise;
      repeat (12) @(negedge clk);
      check(sck == s0 && nrise == r0 && wdata_ready, "R14 sck frozen while no data", nrise, r0);
      wdata_valid = 1;
    end
    wait_ready(n0);
    common_checks($sformatf("prog m%0d", m), D + len * 8 / dl, div, gap, op, ab,
                  a32 ? addr : {8'h0, addr[23:0]}, al, n0);
    bad = 0;
    for (int j = 0; j < len; j++)
      if (seg(D + j * 8 / dl, 8 / dl, dl) != {24'h0, wbyte(j)}) bad++;
    check(bad == 0 && oe_all(D, len * 8 / dl, mask(dl)), $sformatf("R7 R3 write bytes m%0d", m),
          seg(D, 8 / dl, dl), wbyte(0));
    check(widx == len, "R14 bytes consumed", widx, len);
  endtask

  task automatic do_erase(input int s, input bit a32, input logic [31:0] addr);
    logic [7:0] op; int ab, n0;
    op = (s == 0) ? 8'h20 : (s == 1) ? 8'hD8 : 8'hC7;
    ab = (s >= 2) ? 0 : (a32 ? 32 : 24);
    set_cfg(a32, 1, 0, 2, addr, 0); erase_sel = 2'(s); n0 = nready;
    pulse(2); wait_ready(n0);
    common_checks($sformatf("R4 erase s%0d", s), 8 + ab, 1, 2, op, ab,
                  a32 ? addr : {8'h0, addr[23:0]}, 1, n0);
  endtask

  task automatic do_misaligned();
    int n0, c0;
    set_cfg(0, 0, 0, 1, 32'h0000_1002, 0); erase_sel = 2'd1; n0 = nready; c0 = ncsf;
    pulse(2); repeat (4) @(negedge clk);
    check(err_align == 1, "R11 err_align set", err_align, 1);
    check(ncsf == c0 && nready == n0 + 1 && !busy, "R11 no bus activity", ncsf, c0);
    do_erase(0, 0, 32'h0000_2000);
    check(err_align == 0, "R13 err_align cleared by next task", err_align, 0);
  endtask

  task automatic do_overrun();
    int n0;
    set_cfg(0, 1, 0, 1, 32'h0012_3454, 2); rd_mode = 3'd0;
    exp_D = 8 + 24 + 8; exp_L = 1; rd_active = 1; nrd = 0; n0 = nready;
    pulse(0); repeat (20) @(negedge clk);
    pulse(1);
    check(overrun == 1, "R13 overrun set", overrun, 1);
    wait_ready(n0); rd_active = 0;
    repeat (10) @(negedge clk);
    check(nready == n0 + 1 && nrise == exp_D + 16 && nrd == 2, "R13 request ignored", nrise, exp_D + 16);
    do_erase(2, 0, 0);
    check(overrun == 0, "R13 overrun cleared", overrun, 0);
  endtask

  initial begin
    repeat (200000) @(negedge clk);
    check(0, "watchdog", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(cs_n == 1 && busy == 0 && io_oe == 0 && ready == 0 && sck == 0, "R1 reset state", cs_n, 1);
    rst_n = 1;
    repeat (4) @(negedge clk);
    check(cs_n == 1 && busy == 0 && sck == 0, "R1 after release", busy, 0);
    do_read(0, 0, 0, 0, 1, 32'h00A1_B2C3, 3);
    do_read(1, 1, 2, 0, 0, 32'h8765_4321, 2);
    do_read(2, 0, 0, 0, 3, 32'h0013_5790, 2);
    do_read(3, 0, 1, 1, 1, 32'h00FE_DCBA, 2);
    do_read(4, 1, 1, 1, 2, 32'hC001_D00D, 4);
    do_prog(0, 0, 0, 1, 32'h0024_6800, 2, 0);
    do_prog(1, 0, 1, 0, 32'h0011_2233, 2, 0);
    do_prog(2, 1, 0, 2, 32'h4455_6677, 3, 0);
    do_prog(3, 0, 2, 1, 32'h0099_AA00, 2, 1);
    do_erase(0, 0, 32'h0003_1000);
    do_erase(1, 1, 32'h1234_0000);
    do_erase(2, 0, 32'h0000_0003);
    do_misaligned();
    do_overrun();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule